// File: doc/BRIEF.md
# Power-Down Mode Controller

This block sequences the operating modes of a small controller system. Its inputs are a sleep strobe from the processor, byte writes to four control registers, an ordinary interrupt line, an external wake interrupt and a hardware standby pin. From these it drives the oscillator enable, the processor clock enable and the bus-master speed selection. It also drives one clock enable per peripheral, a partial-reset pulse for the peripherals that need one, a global reset and an I/O high-impedance control. The processor, the oscillator circuit and the peripherals sit outside the block, which only produces their control signals.

Six operating conditions are arbitrated:

- full speed and divided speed for the bus master;
- sleep, where the processor is halted and everything else runs;
- per-module stop;
- software standby, where everything halts and only the external interrupt wakes the system, followed by a timed oscillator settling window;
- hardware standby, which overrides all the others and ends like a power-on reset.

All state changes take effect on the clock edge that samples their trigger. The outputs follow the registered mode without further delay.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, reading address 0xFF38 returns 0x08, 0xFF3A returns 0x00, 0xFF3C returns 0x3F and 0xFF3D returns 0xFF. Reads are combinational on `reg_addr`, and any other address reads 0x00.
- R2: When bits 2:0 of the clock register (0xFF3A) are nonzero, `bus_med_sel` is 1 and `bus_div_code` equals those bits. A value of 0 gives `bus_med_sel` 0. The peripheral clock enables do not depend on this field.
- R3: In run mode, a `sleep_req` with bit 7 of the standby register (0xFF38) clear enters sleep. From the next cycle `cpu_clk_en` is 0, `osc_en` is 1 and `mod_clk_en` is unchanged.
- R4: In sleep, either `irq` or `ext_irq` returns the block to run mode, and `cpu_clk_en` is 1 from the next cycle.
- R5: In run and sleep, `mod_clk_en[i]` is the inverse of module stop bit i. Bits 15:8 come from register 0xFF3C and bits 7:0 from 0xFF3D, and a set bit stops the module.
- R6: `part_rst[i]` pulses high for exactly one cycle, in the first cycle in which `mod_clk_en[i]` is low after being high, but only for modules in `PRST_MASK` (default 0x0060, modules 5 and 6). It stays low for every other module.
- R7: In run mode, a `sleep_req` with standby bit 7 set enters software standby. From the next cycle `osc_en`, `cpu_clk_en` and all of `mod_clk_en` are 0.
- R8: In software standby, `irq` and `sleep_req` have no effect. Only `ext_irq` leaves software standby.
- R9: After `ext_irq` in software standby, `osc_en` is 1 and `cpu_clk_en` stays 0 for exactly N cycles, and then run mode resumes. N is 8 shifted left by sel, where sel is bits 3:0 of the standby register, limited to 8, so N runs from 8 to 2048.
- R10: While `hw_standby` is high, from the next cycle and from any mode, `osc_en`, `cpu_clk_en` and `mod_clk_en` are 0, and `glob_rst` and `io_hiz` are 1.
- R11: While `hw_standby` is high, all four registers are held at their reset values and writes are ignored. The cycle after the pin is released, the block is in run mode at full speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sleep_req | input | 1 | Sleep instruction strobe |
| irq | input | 1 | Any interrupt request |
| ext_irq | input | 1 | External interrupt request |
| hw_standby | input | 1 | Hardware standby pin, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | Processor clock enable |
| bus_med_sel | output | 1 | Bus master runs on the divided clock |
| bus_div_code | output | 3 | Divide ratio code for the bus master |
| mod_clk_en | output | 16 | Per-module clock enables |
| part_rst | output | 16 | Partial-reset pulse per module |
| glob_rst | output | 1 | Global reset during hardware standby |
| io_hiz | output | 1 | I/O high-impedance control |

## Verification
The bench fires an ordinary interrupt into software standby. A design that treated every interrupt alike would wake there, and `osc_en` would rise too early. It measures the settling window at select values 0, 2 and 9. This catches an off-by-one counter and a missing limit, which would give 4096 cycles or a wrapped count. It raises the hardware standby pin from sleep, from software standby and from the settling window, and checks that register contents written earlier read back as reset values. A controller that let a mode take priority over the pin, or that kept its registers, fails there. It also stops a masked module and an unmasked one, which exposes a partial reset that is missing, lasts too long or reaches the wrong module.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 12;

  localparam logic [ADDR_W-1:0] A_STBY  = 16'hFF38;
  localparam logic [ADDR_W-1:0] A_CLK   = 16'hFF3A;
  localparam logic [ADDR_W-1:0] A_MSTPH = 16'hFF3C;
  localparam logic [ADDR_W-1:0] A_MSTPL = 16'hFF3D;

  localparam logic [DATA_W-1:0] RV_STBY  = 8'h08;
  localparam logic [DATA_W-1:0] RV_CLK   = 8'h00;
  localparam logic [DATA_W-1:0] RV_MSTPH = 8'h3F;
  localparam logic [DATA_W-1:0] RV_MSTPL = 8'hFF;

  localparam int SETTLE_SEL_MAX = 8;

  typedef enum logic [2:0] {
    PM_RUN, PM_SLEEP, PM_SWSTBY, PM_SETTLE, PM_HWSTBY
  } pm_state_e;

  // number of settling cycles for a select code: 8 << min(sel, 8)
  function automatic logic [CNT_W-1:0] settle_len(input logic [3:0] sel);
    logic [3:0] s;
    s = (sel > 4'(SETTLE_SEL_MAX)) ? 4'(SETTLE_SEL_MAX) : sel;
    return CNT_W'(8) << s;
  endfunction

  function automatic logic is_medium(input logic [2:0] code);
    return code != 3'd0;
  endfunction

endpackage

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_clr,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              stby_sw,
  output logic [3:0]        settle_sel,
  output logic [2:0]        div_code,
  output logic [2*DATA_W-1:0] mstop
);

  logic [DATA_W-1:0] stby_q, clk_q, mstph_q, mstpl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_q  <= RV_STBY;
      clk_q   <= RV_CLK;
      mstph_q <= RV_MSTPH;
      mstpl_q <= RV_MSTPL;
    end else if (hw_clr) begin
      stby_q  <= RV_STBY;
      clk_q   <= RV_CLK;
      mstph_q <= RV_MSTPH;
      mstpl_q <= RV_MSTPL;
    end else if (reg_we) begin
      case (reg_addr)
        A_STBY:  stby_q  <= reg_wdata;
        A_CLK:   clk_q   <= reg_wdata;
        A_MSTPH: mstph_q <= reg_wdata;
        A_MSTPL: mstpl_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_STBY:  reg_rdata = stby_q;
      A_CLK:   reg_rdata = clk_q;
      A_MSTPH: reg_rdata = mstph_q;
      A_MSTPL: reg_rdata = mstpl_q;
      default: reg_rdata = '0;
    endcase
  end

  assign stby_sw    = stby_q[7];
  assign settle_sel = stby_q[3:0];
  assign div_code   = clk_q[2:0];
  assign mstop      = {mstph_q, mstpl_q};

  AST_HW_CLEARS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr |=> (stby_q == RV_STBY && clk_q == RV_CLK &&
                mstph_q == RV_MSTPH && mstpl_q == RV_MSTPL)); // R11

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       irq,
  input  logic       ext_irq,
  input  logic       hw_standby,
  input  logic       stby_sw,
  input  logic [3:0] settle_sel,
  output logic       osc_en,
  output logic       cpu_clk_en,
  output logic       mods_allowed,
  output logic       in_hw_stby
);

  pm_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             wake_sleep, wake_stby, settle_done;

  assign wake_sleep  = irq | ext_irq;
  assign wake_stby   = ext_irq;
  assign settle_done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PM_RUN;
      cnt   <= '0;
    end else if (hw_standby) begin
      state <= PM_HWSTBY;
      cnt   <= '0;
    end else begin
      case (state)
        PM_RUN:    if (sleep_req) state <= stby_sw ? PM_SWSTBY : PM_SLEEP;
        PM_SLEEP:  if (wake_sleep) state <= PM_RUN;
        PM_SWSTBY: if (wake_stby) begin
                     state <= PM_SETTLE;
                     cnt   <= settle_len(settle_sel) - CNT_W'(1);
                   end
        PM_SETTLE: if (settle_done) state <= PM_RUN;
                   else cnt <= cnt - CNT_W'(1);
        PM_HWSTBY: state <= PM_RUN;
        default:   state <= PM_RUN;
      endcase
    end
  end

  assign osc_en       = (state == PM_RUN) || (state == PM_SLEEP) || (state == PM_SETTLE);
  assign cpu_clk_en   = (state == PM_RUN);
  assign mods_allowed = (state == PM_RUN) || (state == PM_SLEEP);
  assign in_hw_stby   = (state == PM_HWSTBY);

  AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_SLEEP && wake_sleep && !hw_standby) |=> cpu_clk_en); // R4
  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_SWSTBY && !ext_irq && !hw_standby) |=> !osc_en); // R8
  AST_SETTLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_SETTLE && !settle_done && !hw_standby) |=>
      (state == PM_SETTLE && cnt == $past(cnt) - CNT_W'(1))); // R9
  AST_HW_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby |=> (in_hw_stby && !osc_en && !cpu_clk_en)); // R10

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate #(
  parameter int           N_MOD     = 16,
  parameter logic [N_MOD-1:0] PRST_MASK = 16'h0060
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mods_allowed,
  input  logic [N_MOD-1:0] mstop,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic [N_MOD-1:0] part_rst
);

  logic [N_MOD-1:0] en_prev;

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    assign mod_clk_en[i] = mods_allowed & ~mstop[i];
    if (PRST_MASK[i]) begin : g_prst
      assign part_rst[i] = en_prev[i] & ~mod_clk_en[i];
    end else begin : g_noprst
      assign part_rst[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= '0;
    else        en_prev <= mod_clk_en;
  end

  AST_PRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (part_rst != '0) |=> ((part_rst & $past(part_rst)) == '0)); // R6

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter logic [15:0] PRST_MASK = 16'h0060
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_req,
  input  logic        irq,
  input  logic        ext_irq,
  input  logic        hw_standby,
  input  logic        reg_we,
  input  logic [15:0] reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        osc_en,
  output logic        cpu_clk_en,
  output logic        bus_med_sel,
  output logic [2:0]  bus_div_code,
  output logic [15:0] mod_clk_en,
  output logic [15:0] part_rst,
  output logic        glob_rst,
  output logic        io_hiz
);

  localparam int N_MOD = 2 * DATA_W;

  logic             stby_sw, mods_allowed, in_hw_stby;
  logic [3:0]       settle_sel;
  logic [2:0]       div_code;
  logic [N_MOD-1:0] mstop;

  pwr_regs u_regs (
    .clk, .rst_n, .hw_clr(hw_standby), .reg_we, .reg_addr, .reg_wdata,
    .reg_rdata, .stby_sw, .settle_sel, .div_code, .mstop
  );

  pwr_fsm u_fsm (
    .clk, .rst_n, .sleep_req, .irq, .ext_irq, .hw_standby, .stby_sw,
    .settle_sel, .osc_en, .cpu_clk_en, .mods_allowed, .in_hw_stby
  );

  pwr_clk_gate #(.N_MOD(N_MOD), .PRST_MASK(PRST_MASK)) u_gate (
    .clk, .rst_n, .mods_allowed, .mstop, .mod_clk_en, .part_rst
  );

  assign bus_med_sel  = is_medium(div_code);
  assign bus_div_code = div_code;
  assign glob_rst     = in_hw_stby;
  assign io_hiz       = in_hw_stby;

  AST_OSC_OFF_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk_en && mod_clk_en == '0)); // R7

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n, sleep_req, irq, ext_irq, hw_standby, reg_we;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        osc_en, cpu_clk_en, bus_med_sel, glob_rst, io_hiz;
  logic [2:0]  bus_div_code;
  logic [15:0] mod_clk_en, part_rst;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (.*);

  // vector: [6]sleep [5]irq [4]ext [3]hw | expected [2]cpu [1]osc [0]hiz
  localparam logic [6:0] VEC [10] = '{
    7'b1000_010, 7'b0000_010, 7'b0100_110, 7'b1000_010, 7'b0010_110,
    7'b1000_010, 7'b0001_001, 7'b0001_001, 7'b0000_110, 7'b0100_110
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    reg_addr = a; #0.5;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic pulse_sleep(); sleep_req = 1'b1; tick(); sleep_req = 1'b0; endtask
  task automatic pulse_ext();   ext_irq = 1'b1;   tick(); ext_irq = 1'b0;   endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; sleep_req = 0; irq = 0; ext_irq = 0; hw_standby = 0;
    reg_we = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset values
    rd_chk("R1 stby", 16'hFF38, 8'h08);
    rd_chk("R1 clk", 16'hFF3A, 8'h00);
    rd_chk("R1 mstph", 16'hFF3C, 8'h3F);
    rd_chk("R1 mstpl", 16'hFF3D, 8'hFF);
    rd_chk("R1 other", 16'hFF39, 8'h00);
    chk("R1 cpu", 32'(cpu_clk_en), 1);
    chk("R5 reset enables", 32'(mod_clk_en), 32'hC000);

    // R2 medium speed
    wr(16'hFF3A, 8'h03);
    chk("R2 med", 32'(bus_med_sel), 1);
    chk("R2 code", 32'(bus_div_code), 3);
    chk("R2 mods", 32'(mod_clk_en), 32'hC000);
    wr(16'hFF3A, 8'h00);
    chk("R2 full", 32'(bus_med_sel), 0);

    // R5 module stop mapping
    wr(16'hFF3D, 8'h00);
    chk("R5 low", 32'(mod_clk_en), 32'hC0FF);
    wr(16'hFF3C, 8'h3E);
    chk("R5 high", 32'(mod_clk_en), 32'hC1FF);

    // R6 partial reset
    wr(16'hFF3D, 8'h20);
    chk("R6 pulse", 32'(part_rst), 32'h0020);
    tick();
    chk("R6 one cycle", 32'(part_rst), 0);
    wr(16'hFF3D, 8'h21);
    chk("R6 unmasked", 32'(part_rst), 0);
    wr(16'hFF3D, 8'h00);

    // R3 sleep keeps modules running
    pulse_sleep();
    chk("R3 cpu", 32'(cpu_clk_en), 0);
    chk("R3 osc", 32'(osc_en), 1);
    chk("R3 mods", 32'(mod_clk_en), 32'hC1FF);
    irq = 1; tick(); irq = 0;
    chk("R4 irq wake", 32'(cpu_clk_en), 1);

    // table: sleep/wake/hardware standby sequence (R3 R4 R10 R11)
    for (int i = 0; i < 10; i++) begin
      sleep_req = VEC[i][6]; irq = VEC[i][5]; ext_irq = VEC[i][4]; hw_standby = VEC[i][3];
      tick();
      sleep_req = 0; irq = 0; ext_irq = 0;
      chk($sformatf("R4/R10 vec%0d cpu", i), 32'(cpu_clk_en), 32'(VEC[i][2]));
      chk($sformatf("R4/R10 vec%0d osc", i), 32'(osc_en), 32'(VEC[i][1]));
      chk($sformatf("R10 vec%0d hiz", i), 32'(io_hiz), 32'(VEC[i][0]));
      if (i == 6) begin
        chk("R10 glob_rst", 32'(glob_rst), 1);
        chk("R10 mods", 32'(mod_clk_en), 0);
      end
    end
    hw_standby = 0;
    rd_chk("R11 mstph reset", 16'hFF3C, 8'h3F);
    rd_chk("R11 mstpl reset", 16'hFF3D, 8'hFF);
    chk("R11 full speed", 32'(bus_med_sel), 0);

    // R7 R8 R9 software standby, settle 8
    wr(16'hFF38, 8'h80);
    wr(16'hFF3D, 8'h00);
    pulse_sleep();
    chk("R7 osc", 32'(osc_en), 0);
    chk("R7 cpu", 32'(cpu_clk_en), 0);
    chk("R7 mods", 32'(mod_clk_en), 0);
    chk("R6 standby pulse", 32'(part_rst), 32'h0060);
    irq = 1; tick(); irq = 0;
    chk("R8 irq ignored", 32'(osc_en), 0);
    pulse_sleep();
    chk("R8 sleep ignored", 32'(osc_en), 0);
    pulse_ext();
    chk("R9 osc on", 32'(osc_en), 1);
    repeat (7) tick();
    chk("R9 settle 8 held", 32'(cpu_clk_en), 0);
    tick();
    chk("R9 settle 8 done", 32'(cpu_clk_en), 1);
    chk("R5 after wake", 32'(mod_clk_en), 32'hC0FF);

    // R9 settle 32
    wr(16'hFF38, 8'h82);
    pulse_sleep();
    pulse_ext();
    repeat (31) tick();
    chk("R9 settle 32 held", 32'(cpu_clk_en), 0);
    tick();
    chk("R9 settle 32 done", 32'(cpu_clk_en), 1);

    // R9 clamp at 2048
    wr(16'hFF38, 8'h89);
    pulse_sleep();
    pulse_ext();
    n = 0;
    while (!cpu_clk_en && n < 5000) begin tick(); n++; end
    chk("R9 clamp 2048", 32'(n), 2048);

    // R10 pre-empts software standby
    wr(16'hFF38, 8'h80);
    pulse_sleep();
    hw_standby = 1; tick();
    chk("R10 from standby", 32'(io_hiz), 1);
    wr(16'hFF3A, 8'h05);
    hw_standby = 0; tick();
    chk("R11 run after release", 32'(cpu_clk_en), 1);
    rd_chk("R11 write ignored", 16'hFF3A, 8'h00);
    rd_chk("R11 stby reset", 16'hFF38, 8'h08);

    // R10 pre-empts settling
    wr(16'hFF38, 8'h88);
    pulse_sleep();
    pulse_ext();
    repeat (3) tick();
    hw_standby = 1; tick();
    chk("R10 from settle", 32'(glob_rst), 1);
    chk("R10 osc off", 32'(osc_en), 0);
    hw_standby = 0; tick();
    chk("R11 release", 32'(cpu_clk_en), 1);

    // R8 ext in run has no effect
    pulse_ext();
    chk("R8 ext in run", 32'(cpu_clk_en), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule